// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside an instruction decoder. It takes the hart's current privilege level, its virtualization bit and a handful of control-status fields. From these it produces two groups of combinational flags, one flag per instruction class. The first group says the class must raise an illegal-instruction exception. The second says it must raise a virtual-instruction exception. The rules follow a hypervisor-aware privilege model that has five effective modes: M, HS, HU, VS and VU. A fault that the host owns is reported as illegal. A fault that belongs to a guest and must be handed to the hypervisor is reported as virtual.

The decoder may also present one decoded instruction class with a valid strobe. One clock later the block returns a registered two-bit verdict for that class (none, illegal or virtual). The verdict comes with its own valid bit. The flag outputs let several decoder lanes share one checker. The registered verdict suits a single lane that wants a timed answer.

Top module: `priv_legality_chk`

## Requirements
- R1: Mode decode: priv 2'b11 is M, 2'b01 is S, 2'b00 is U, and 2'b10 is treated as U. When virt is 0, S and U are HS and HU. When virt is 1, S and U are VS and VU. In M the virt bit is ignored.
- R2: ill_o[0] (page-table fence/invalidate) and ill_o[2] (guest-physical hypervisor fence) are 1 in HU, and in HS when tvm is 1. They are 0 otherwise.
- R3: ill_o[1] (partial fences: write-invalidate and invalidate-ir) and ill_o[3] (virtual-VM hypervisor fence) are 1 only in HU.
- R4: ill_o[4] (hypervisor load/store) is 1 only in HU with hu = 0.
- R5: ill_o[5] (any floating-point instruction) is 1 when fs = 2'b00 (Off), in every mode. ill_o[6] (any vector instruction) is 1 when vs = 2'b00 (Off), in every mode.
- R6: ill_o[7] (wait-for-interrupt) is 1 in HU, and in any non-M mode when tw is 1.
- R7: ill_o[8] (dynamic rounding) is 1 when frm is greater than 4. At frm = 4 it is 0.
- R8: virt_o[0] (page-table fence) is 1 in VU, and in VS when vtvm is 1. virt_o[1] (partial fences) is 1 only in VU.
- R9: virt_o[2] (any hypervisor fence) and virt_o[3] (hypervisor load/store) are 1 in VS or VU. They are 0 in M, HS and HU.
- R10: virt_o[4] (wait-for-interrupt) is 1 in VU when tw is 0, and in VS when tw is 0 and vtw is 1.
- R11: With cls_valid_i = 1 the verdict appears on the next clock, with verdict_vld_o = 1. The verdict codes are 2'b00 none, 2'b01 illegal and 2'b10 virtual. The class codes and the flags that decide each one:
  - 1: page-table fence, using ill bit 0 and virt bit 0.
  - 2: partial fence, using ill bit 1 and virt bit 1.
  - 3: guest-physical hypervisor fence, using ill bit 2 and virt bit 2.
  - 4: virtual-VM hypervisor fence, using ill bit 3 and virt bit 2.
  - 5: hypervisor load/store, using ill bit 4 and virt bit 3.
  - 6: floating-point, using ill bit 5.
  - 7: floating-point with dynamic rounding, using ill bit 5 or ill bit 8.
  - 8: vector, using ill bit 6.
  - 9: wait-for-interrupt, using ill bit 7 and virt bit 4.
  - 0 and 10 to 15: always none.
  
  If a class is both illegal and virtual, illegal wins.
- R12: With cls_valid_i = 0, the next clock gives verdict_vld_o = 0 and verdict_o = 2'b00. Synchronous reset (rst_i = 1) sets both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| priv_i | input | 2 | Privilege level |
| virt_i | input | 1 | Virtualization bit |
| tvm_i | input | 1 | Trap virtual-memory bit of the machine status |
| tw_i | input | 1 | Timeout-wait bit of the machine status |
| fs_i | input | 2 | Floating-point state field (00 = Off) |
| vs_i | input | 2 | Vector state field (00 = Off) |
| hu_i | input | 1 | Hypervisor-status bit that allows hypervisor loads and stores in U |
| vtvm_i | input | 1 | Hypervisor-status virtual trap-VM bit |
| vtw_i | input | 1 | Hypervisor-status virtual timeout-wait bit |
| frm_i | input | FRM_W | Floating-point rounding-mode field |
| cls_valid_i | input | 1 | Decoded class is valid |
| cls_i | input | 4 | Decoded instruction class |
| ill_o | output | 9 | Illegal-instruction flags per class |
| virt_o | output | 5 | Virtual-instruction flags per class |
| verdict_o | output | 2 | Registered verdict |
| verdict_vld_o | output | 1 | Registered verdict is valid |

## Verification
The bench sweeps every privilege encoding and virtualization value against all combinations of the trap bits, and checks each flag against a reference written from the rules. Several corner cases get their own attention:
- The reserved encoding 2'b10. A design that treats it as S would let HU-only faults slip through.
- M mode with the virt bit set. Decoding this as a guest would raise spurious virtual faults.
- A rounding mode of exactly 4. An off-by-one comparison would flag a legal mode.
- Wait-for-interrupt in VS with tw set. It must be illegal rather than virtual.

The registered verdict is streamed back to back across all sixteen class codes. Idle and reset cycles are checked to confirm that no stale verdict survives.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;

    localparam int ILL_N  = 9;
    localparam int VIRT_N = 5;
    localparam int CLS_W  = 4;

    // illegal flag bit positions
    localparam int IB_FVMA  = 0;
    localparam int IB_FPART = 1;
    localparam int IB_HFG   = 2;
    localparam int IB_HFV   = 3;
    localparam int IB_HLS   = 4;
    localparam int IB_FSOFF = 5;
    localparam int IB_VSOFF = 6;
    localparam int IB_WFI   = 7;
    localparam int IB_FRM   = 8;

    // virtual flag bit positions
    localparam int VB_FVMA  = 0;
    localparam int VB_FPART = 1;
    localparam int VB_HF    = 2;
    localparam int VB_HLS   = 3;
    localparam int VB_WFI   = 4;

    localparam logic [1:0] PRV_U = 2'b00;
    localparam logic [1:0] PRV_S = 2'b01;
    localparam logic [1:0] PRV_M = 2'b11;

    typedef struct packed {
        logic m;
        logic hs;
        logic hu;
        logic vs;
        logic vu;
    } mode_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 4'd0,
        CLS_FVMA   = 4'd1,
        CLS_FPART  = 4'd2,
        CLS_HFG    = 4'd3,
        CLS_HFV    = 4'd4,
        CLS_HLS    = 4'd5,
        CLS_FP     = 4'd6,
        CLS_FP_DYN = 4'd7,
        CLS_VEC    = 4'd8,
        CLS_WFI    = 4'd9
    } cls_e;

    typedef enum logic [1:0] {
        VRD_NONE = 2'b00,
        VRD_ILL  = 2'b01,
        VRD_VIRT = 2'b10
    } verdict_e;

endpackage

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
    import priv_chk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    output mode_t      mode_o
);

    logic is_m;
    logic is_s;

    always_comb begin
        is_m = (priv_i == PRV_M);
        is_s = (priv_i == PRV_S);
        // 2'b00 and the reserved 2'b10 both fall to U
        mode_o.m  = is_m;
        mode_o.hs = is_s && !virt_i;
        mode_o.vs = is_s && virt_i;
        mode_o.hu = !is_m && !is_s && !virt_i;
        mode_o.vu = !is_m && !is_s && virt_i;
    end

    // R1
    one_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(mode_o) == 1);

endmodule

// File: rtl/priv_ill_rules.sv
module priv_ill_rules
    import priv_chk_pkg::*;
#(
    parameter int FRM_W     = 3,
    parameter int FRM_LIMIT = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  mode_t            mode_i,
    input  logic             tvm_i,
    input  logic             tw_i,
    input  logic [1:0]       fs_i,
    input  logic [1:0]       vs_i,
    input  logic             hu_i,
    input  logic [FRM_W-1:0] frm_i,
    output logic [ILL_N-1:0] ill_o
);

    localparam logic [FRM_W-1:0] FRM_MAX = FRM_W'(FRM_LIMIT);

    logic vm_trap;

    always_comb begin
        vm_trap          = mode_i.hu || (mode_i.hs && tvm_i);
        ill_o            = '0;
        ill_o[IB_FVMA]   = vm_trap;
        ill_o[IB_HFG]    = vm_trap;
        ill_o[IB_FPART]  = mode_i.hu;
        ill_o[IB_HFV]    = mode_i.hu;
        ill_o[IB_HLS]    = mode_i.hu && !hu_i;
        ill_o[IB_FSOFF]  = (fs_i == 2'b00);
        ill_o[IB_VSOFF]  = (vs_i == 2'b00);
        ill_o[IB_WFI]    = mode_i.hu || (!mode_i.m && tw_i);
        ill_o[IB_FRM]    = (frm_i > FRM_MAX);
    end

    // R6
    m_wfi_ok_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_i.m |-> !ill_o[IB_WFI]);

    // R2
    m_fence_ok_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_i.m |-> (ill_o[IB_HLS:IB_FVMA] == '0));

endmodule

// File: rtl/priv_virt_rules.sv
module priv_virt_rules
    import priv_chk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              is_vs_i,
    input  logic              is_vu_i,
    input  logic              tw_i,
    input  logic              vtvm_i,
    input  logic              vtw_i,
    output logic [VIRT_N-1:0] virt_o
);

    logic guest;

    always_comb begin
        guest            = is_vs_i || is_vu_i;
        virt_o           = '0;
        virt_o[VB_FVMA]  = is_vu_i || (is_vs_i && vtvm_i);
        virt_o[VB_FPART] = is_vu_i;
        virt_o[VB_HF]    = guest;
        virt_o[VB_HLS]   = guest;
        virt_o[VB_WFI]   = !tw_i && (is_vu_i || (is_vs_i && vtw_i));
    end

    // R9
    host_no_virt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(is_vs_i || is_vu_i) |-> (virt_o == '0));

    // R10
    tw_blocks_virt_wfi_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tw_i |-> !virt_o[VB_WFI]);

endmodule

// File: rtl/priv_verdict_reg.sv
module priv_verdict_reg
    import priv_chk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cls_valid_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [ILL_N-1:0]  ill_i,
    input  logic [VIRT_N-1:0] virt_i,
    output logic [1:0]        verdict_o,
    output logic              verdict_vld_o
);

    logic     ill_hit;
    logic     virt_hit;
    verdict_e verdict_q;
    verdict_e verdict_d;
    logic     vld_q;

    always_comb begin
        ill_hit  = 1'b0;
        virt_hit = 1'b0;
        case (cls_i)
            CLS_FVMA: begin
                ill_hit  = ill_i[IB_FVMA];
                virt_hit = virt_i[VB_FVMA];
            end
            CLS_FPART: begin
                ill_hit  = ill_i[IB_FPART];
                virt_hit = virt_i[VB_FPART];
            end
            CLS_HFG: begin
                ill_hit  = ill_i[IB_HFG];
                virt_hit = virt_i[VB_HF];
            end
            CLS_HFV: begin
                ill_hit  = ill_i[IB_HFV];
                virt_hit = virt_i[VB_HF];
            end
            CLS_HLS: begin
                ill_hit  = ill_i[IB_HLS];
                virt_hit = virt_i[VB_HLS];
            end
            CLS_FP:     ill_hit = ill_i[IB_FSOFF];
            CLS_FP_DYN: ill_hit = ill_i[IB_FSOFF] || ill_i[IB_FRM];
            CLS_VEC:    ill_hit = ill_i[IB_VSOFF];
            CLS_WFI: begin
                ill_hit  = ill_i[IB_WFI];
                virt_hit = virt_i[VB_WFI];
            end
            default: begin
                ill_hit  = 1'b0;
                virt_hit = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (!cls_valid_i)  verdict_d = VRD_NONE;
        else if (ill_hit)  verdict_d = VRD_ILL;
        else if (virt_hit) verdict_d = VRD_VIRT;
        else               verdict_d = VRD_NONE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            verdict_q <= VRD_NONE;
            vld_q     <= 1'b0;
        end else begin
            verdict_q <= verdict_d;
            vld_q     <= cls_valid_i;
        end
    end

    assign verdict_o     = verdict_q;
    assign verdict_vld_o = vld_q;

    // R11
    ill_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cls_valid_i && ill_hit) |=> (verdict_o == VRD_ILL && verdict_vld_o));

    // R11
    virt_next_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cls_valid_i && !ill_hit && virt_hit) |=> (verdict_o == VRD_VIRT));

    // R12
    idle_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !cls_valid_i |=> (verdict_o == VRD_NONE && !verdict_vld_o));

endmodule

// File: rtl/priv_legality_chk.sv
module priv_legality_chk
    import priv_chk_pkg::*;
#(
    parameter int FRM_W     = 3,
    parameter int FRM_LIMIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              tvm_i,
    input  logic              tw_i,
    input  logic [1:0]        fs_i,
    input  logic [1:0]        vs_i,
    input  logic              hu_i,
    input  logic              vtvm_i,
    input  logic              vtw_i,
    input  logic [FRM_W-1:0]  frm_i,
    input  logic              cls_valid_i,
    input  logic [CLS_W-1:0]  cls_i,
    output logic [ILL_N-1:0]  ill_o,
    output logic [VIRT_N-1:0] virt_o,
    output logic [1:0]        verdict_o,
    output logic              verdict_vld_o
);

    mode_t mode;

    priv_mode_decode u_mode (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .priv_i (priv_i),
        .virt_i (virt_i),
        .mode_o (mode)
    );

    priv_ill_rules #(
        .FRM_W     (FRM_W),
        .FRM_LIMIT (FRM_LIMIT)
    ) u_ill (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mode_i (mode),
        .tvm_i  (tvm_i),
        .tw_i   (tw_i),
        .fs_i   (fs_i),
        .vs_i   (vs_i),
        .hu_i   (hu_i),
        .frm_i  (frm_i),
        .ill_o  (ill_o)
    );

    priv_virt_rules u_virt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .is_vs_i (mode.vs),
        .is_vu_i (mode.vu),
        .tw_i    (tw_i),
        .vtvm_i  (vtvm_i),
        .vtw_i   (vtw_i),
        .virt_o  (virt_o)
    );

    priv_verdict_reg u_vrd (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .cls_valid_i   (cls_valid_i),
        .cls_i         (cls_i),
        .ill_i         (ill_o),
        .virt_i        (virt_o),
        .verdict_o     (verdict_o),
        .verdict_vld_o (verdict_vld_o)
    );

    // R8: host-owned and guest-owned faults never coincide for one class
    disjoint_fault_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !((ill_o[IB_FVMA] && virt_o[VB_FVMA]) ||
          (ill_o[IB_FPART] && virt_o[VB_FPART]) ||
          ((ill_o[IB_HFG] || ill_o[IB_HFV]) && virt_o[VB_HF]) ||
          (ill_o[IB_HLS] && virt_o[VB_HLS]) ||
          (ill_o[IB_WFI] && virt_o[VB_WFI])));

endmodule

// File: tb/priv_legality_chk_tb_top.sv
module priv_legality_chk_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] priv;
    logic       virt, tvm, tw, hu, vtvm, vtw, cls_valid;
    logic [1:0] fs, vs;
    logic [2:0] frm;
    logic [3:0] cls;
    logic [8:0] ill;
    logic [4:0] vflg;
    logic [1:0] verdict;
    logic       verdict_vld;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    priv_legality_chk dut_i (
        .clk_i(clk), .rst_i(rst), .priv_i(priv), .virt_i(virt),
        .tvm_i(tvm), .tw_i(tw), .fs_i(fs), .vs_i(vs), .hu_i(hu),
        .vtvm_i(vtvm), .vtw_i(vtw), .frm_i(frm),
        .cls_valid_i(cls_valid), .cls_i(cls),
        .ill_o(ill), .virt_o(vflg),
        .verdict_o(verdict), .verdict_vld_o(verdict_vld)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic logic [8:0] ref_ill();
        logic m, s, hs, hu_m;
        logic [8:0] r;
        m    = (priv == 2'b11);
        s    = (priv == 2'b01);
        hs   = s && !virt;
        hu_m = !m && !s && !virt;
        r    = '0;
        r[0] = hu_m || (hs && tvm);
        r[2] = r[0];
        r[1] = hu_m;
        r[3] = hu_m;
        r[4] = hu_m && !hu;
        r[5] = (fs == 2'b00);
        r[6] = (vs == 2'b00);
        r[7] = hu_m || (!m && tw);
        r[8] = (frm > 3'd4);
        return r;
    endfunction

    function automatic logic [4:0] ref_virt();
        logic m, s, vsm, vum;
        logic [4:0] r;
        m   = (priv == 2'b11);
        s   = (priv == 2'b01);
        vsm = s && virt;
        vum = !m && !s && virt;
        r    = '0;
        r[0] = vum || (vsm && vtvm);
        r[1] = vum;
        r[2] = vsm || vum;
        r[3] = vsm || vum;
        r[4] = !tw && (vum || (vsm && vtw));
        return r;
    endfunction

    function automatic string ill_tag(input int b);
        case (b)
            0, 2: return "R2";
            1, 3: return "R3";
            4: return "R4";
            5, 6: return "R5";
            7: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic string virt_tag(input int b);
        case (b)
            0, 1: return "R8";
            2, 3: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [1:0] ref_verdict(input logic [3:0] c);
        logic [8:0] i;
        logic [4:0] v;
        logic ih, vh;
        i = ref_ill();
        v = ref_virt();
        ih = 1'b0;
        vh = 1'b0;
        case (c)
            4'd1: begin ih = i[0]; vh = v[0]; end
            4'd2: begin ih = i[1]; vh = v[1]; end
            4'd3: begin ih = i[2]; vh = v[2]; end
            4'd4: begin ih = i[3]; vh = v[2]; end
            4'd5: begin ih = i[4]; vh = v[3]; end
            4'd6: ih = i[5];
            4'd7: ih = i[5] | i[8];
            4'd8: ih = i[6];
            4'd9: begin ih = i[7]; vh = v[4]; end
            default: ;
        endcase
        return ih ? 2'b01 : (vh ? 2'b10 : 2'b00);
    endfunction

    task automatic set_state(input logic [1:0] p, input logic v, input logic a_tvm,
                             input logic a_tw, input logic a_hu, input logic a_vtvm,
                             input logic a_vtw);
        priv = p; virt = v; tvm = a_tvm; tw = a_tw; hu = a_hu; vtvm = a_vtvm; vtw = a_vtw;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; cls_valid = 1'b1; cls = 4'd9;
        set_state(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        chk({15'd0, verdict_vld}, 16'd0, "R12 reset vld");
        chk({14'd0, verdict}, 16'd0, "R12 reset verdict");
        cls_valid = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_mode_decode();
        @(negedge clk);
        fs = 2'b11; vs = 2'b11; frm = 3'd0;
        set_state(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk({15'd0, ill[7]}, 16'd1, "R1 reserved encoding acts as HU (wfi)");
        chk({15'd0, ill[1]}, 16'd1, "R1 reserved encoding acts as HU (partial fence)");
        set_state(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk({11'd0, vflg}, 16'd0, "R1 M ignores virt bit (virt flags)");
        chk({7'd0, ill}, 16'd0, "R1 M ignores virt bit (ill flags)");
        set_state(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({15'd0, vflg[1]}, 16'd1, "R1 reserved encoding with virt acts as VU");
    endtask

    task automatic t_fences();
        set_state(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk({14'd0, ill[2], ill[0]}, 16'd3, "R2 HS tvm=1");
        chk({14'd0, ill[3], ill[1]}, 16'd0, "R3 HS partial/vvma legal");
        set_state(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk({14'd0, ill[2], ill[0]}, 16'd0, "R2 HS tvm=0");
        set_state(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk({14'd0, ill[2], ill[0]}, 16'd3, "R2 HU");
        chk({14'd0, ill[3], ill[1]}, 16'd3, "R3 HU");
    endtask

    task automatic t_hyp_ls();
        set_state(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({15'd0, ill[4]}, 16'd1, "R4 HU hu=0");
        set_state(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk({15'd0, ill[4]}, 16'd0, "R4 HU hu=1");
        set_state(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({15'd0, ill[4]}, 16'd0, "R4 HS hu=0");
    endtask

    task automatic t_fp_vec();
        set_state(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        fs = 2'b00; vs = 2'b01; #1;
        chk({14'd0, ill[6], ill[5]}, 16'd1, "R5 fs off in M");
        fs = 2'b10; vs = 2'b00; #1;
        chk({14'd0, ill[6], ill[5]}, 16'd2, "R5 vs off in M");
        fs = 2'b11; vs = 2'b11; #1;
        frm = 3'd4; #1;
        chk({15'd0, ill[8]}, 16'd0, "R7 frm=4 legal");
        frm = 3'd5; #1;
        chk({15'd0, ill[8]}, 16'd1, "R7 frm=5 illegal");
        frm = 3'd7; #1;
        chk({15'd0, ill[8]}, 16'd1, "R7 frm=7 illegal");
        frm = 3'd0; #1;
    endtask

    task automatic t_wfi();
        set_state(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk({15'd0, ill[7]}, 16'd1, "R6 HS tw=1");
        set_state(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk({15'd0, ill[7]}, 16'd0, "R6 M tw=1");
        set_state(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({15'd0, ill[7]}, 16'd0, "R6 HS tw=0");
        set_state(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        chk({14'd0, ill[7], vflg[4]}, 16'd2, "R10 VS tw=1 is illegal not virtual");
        set_state(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({15'd0, vflg[4]}, 16'd1, "R10 VU tw=0");
        set_state(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk({15'd0, vflg[4]}, 16'd1, "R10 VS tw=0 vtw=1");
        set_state(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({15'd0, vflg[4]}, 16'd0, "R10 VS tw=0 vtw=0");
    endtask

    task automatic t_virt_fences();
        set_state(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk({14'd0, vflg[1], vflg[0]}, 16'd1, "R8 VS vtvm=1");
        chk({14'd0, vflg[3], vflg[2]}, 16'd3, "R9 VS hyp fence and ld/st");
        set_state(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({15'd0, vflg[0]}, 16'd0, "R8 VS vtvm=0");
        set_state(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk({14'd0, vflg[1], vflg[0]}, 16'd3, "R8 VU");
        set_state(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk({14'd0, vflg[3], vflg[2]}, 16'd0, "R9 HS no virtual");
    endtask

    task automatic t_sweep();
        for (int p = 0; p < 4; p++)
            for (int v = 0; v < 2; v++)
                for (int b = 0; b < 32; b++)
                    for (int f = 0; f < 8; f++) begin
                        logic [8:0] ei;
                        logic [4:0] ev;
                        set_state(p[1:0], v[0], b[0], b[1], b[2], b[3], b[4]);
                        fs = f[0] ? 2'b01 : 2'b00;
                        vs = f[1] ? 2'b11 : 2'b00;
                        frm = f[2] ? 3'd5 : 3'd3;
                        #1;
                        ei = ref_ill();
                        ev = ref_virt();
                        for (int k = 0; k < 9; k++)
                            chk({15'd0, ill[k]}, {15'd0, ei[k]}, ill_tag(k));
                        for (int k = 0; k < 5; k++)
                            chk({15'd0, vflg[k]}, {15'd0, ev[k]}, virt_tag(k));
                    end
    endtask

    task automatic t_verdict_stream(input logic [1:0] p, input logic v, input logic a_tw,
                                    input logic [1:0] a_fs);
        @(negedge clk);
        set_state(p, v, 1'b1, a_tw, 1'b0, 1'b1, 1'b1);
        fs = a_fs; vs = 2'b00; frm = 3'd6;
        for (int c = 0; c < 16; c++) begin
            logic [1:0] exp;
            cls_valid = 1'b1;
            cls = c[3:0];
            #1;
            exp = ref_verdict(c[3:0]);
            @(posedge clk); @(negedge clk);
            chk({14'd0, verdict}, {14'd0, exp}, "R11 verdict");
            chk({15'd0, verdict_vld}, 16'd1, "R11 verdict valid");
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        set_state(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cls_valid = 1'b1; cls = 4'd9;
        @(posedge clk); @(negedge clk);
        chk({14'd0, verdict}, 16'd1, "R11 HU wfi illegal");
        cls_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({14'd0, verdict}, 16'd0, "R12 idle verdict");
        chk({15'd0, verdict_vld}, 16'd0, "R12 idle vld");
        cls_valid = 1'b1; cls = 4'd1;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk({15'd0, verdict_vld}, 16'd0, "R12 mid-run reset");
        rst = 1'b0;
        cls_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cls_valid = 1'b0; cls = '0;
        priv = '0; virt = 0; tvm = 0; tw = 0; hu = 0; vtvm = 0; vtw = 0;
        fs = 2'b11; vs = 2'b11; frm = '0;
        t_reset();
        t_mode_decode();
        t_fences();
        t_hyp_ls();
        t_fp_vec();
        t_wfi();
        t_virt_fences();
        t_sweep();
        t_verdict_stream(2'b01, 1'b1, 1'b0, 2'b01);
        t_verdict_stream(2'b00, 1'b0, 1'b1, 2'b00);
        t_verdict_stream(2'b00, 1'b1, 1'b0, 2'b11);
        t_verdict_stream(2'b11, 1'b1, 1'b1, 2'b10);
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule